// File: doc/BRIEF.md
# Ratio-2 Synchronous Clock Crossing

This block carries data both ways between a base-rate clock and a second clock that runs at exactly twice that rate and comes from the same source. The edges of the two clocks are related, but the skew between them is only loosely controlled. A word launched on a base-rate edge can therefore arrive close to a fast edge, and a plain two-edge handoff is unsafe. A FIFO is not needed, because the frequency ratio is fixed.

All logic runs on the fast clock. The base-rate clock enters as an ordinary input. A flop on the falling edge of the fast clock samples it, so the sample is taken half a fast period away from any base-rate transition. A one-cycle slot enable is derived from that sample. It marks the fast cycle that begins at a base-rate rising edge, so the fast edge that closes this cycle falls in the middle of the base-rate period. On that edge the block does two things:
- It captures the base-rate word into the fast domain.
- It loads a holding register. The base-rate domain samples this register on its next rising edge, which lies a full fast period away from any change.

The base-rate clock has period 2T and the fast clock has period T, where T is one fast-clock period.

Top module: `ratio2_xing`

## Requirements
- R1: While `rst` is high at a fast rising edge, `slot_en`, `f_out_valid` and `s_out_valid` go to 0, and both data outputs go to all zeros.
- R2: Once running, `slot_en` is high for exactly one fast cycle out of every two. It is high during the fast cycle that begins at the fast edge nearest a rising edge of `clk_slow`.
- R3: After `rst` is released, `slot_en` stays low for at least the first three fast cycles. It stays low until the sampler has registered two transitions of `clk_slow`.
- R4: Each base-rate period in which `s_in_valid` is 1 produces exactly one `f_out_valid` pulse, one fast cycle long, carrying the word on `f_out_data`. The pulse starts at the fast edge that closes the `slot_en` cycle, one fast edge after the `clk_slow` rising edge that launched the word. Words arrive in order, none lost and none repeated.
- R5: A base-rate period in which `s_in_valid` is 0 produces no `f_out_valid` pulse, and `f_out_data` keeps the last delivered word.
- R6: The values on `f_in_data` and `f_in_valid` during a `slot_en` cycle are copied to `s_out_data` and `s_out_valid` at the fast edge that closes that cycle. The copies then stay constant for two fast cycles, which covers the next `clk_slow` rising edge.
- R7: Values on `f_in_data` and `f_in_valid` that are present only while `slot_en` is low never reach `s_out_data` or `s_out_valid`.
- R8: R2, R4 and R6 hold when each `clk_slow` edge is offset from its nominal fast edge by any amount up to a quarter fast period, early or late, varying from edge to edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Clock at twice the base rate; every flop in the block runs on it |
| rst | input | 1 | Synchronous active-high reset, fast domain |
| clk_slow | input | 1 | Base-rate clock, taken in as data and sampled on falling fast edges |
| s_in_data | input | DW | Word launched by the base-rate domain |
| s_in_valid | input | 1 | Marks `s_in_data` as a real word for this base-rate period |
| f_out_data | output | DW | Last word delivered into the fast domain |
| f_out_valid | output | 1 | One-fast-cycle pulse per delivered word |
| f_in_data | input | DW | Word offered by the fast domain; taken only in a `slot_en` cycle |
| f_in_valid | input | 1 | Marks `f_in_data` as a real word |
| s_out_data | output | DW | Held word for the base-rate domain |
| s_out_valid | output | 1 | Valid flag held alongside `s_out_data` |
| slot_en | output | 1 | Recovered phase enable; high in the cycle whose closing edge is the safe transfer point |

## Verification
On every cycle the assertions check the following:
- The alternation of the slot enable and its two-cycle period.
- The quiet window after reset.
- That every output pulse is one cycle long and traces back to an enabled, valid input.
- That both data outputs stay frozen outside the events allowed to change them.

Only the bench scenarios can show the end-to-end results. These are:
- Each word arrives on the expected fast edge, in order, with no loss or duplication.
- Junk offered during off-phase cycles never reaches the base-rate side.
- All of this stays true while the base-rate edges move early and late by up to a quarter fast period from edge to edge.

// File: rtl/rc2_pkg.sv
`timescale 1ns/1ps
package rc2_pkg;
  // Default word width carried in each direction.
  localparam int unsigned RC2_DW = 16;
  // Sampled base-clock transitions required before the slot enable is trusted.
  localparam int unsigned RC2_ARM_EDGES = 2;
  // Width of a counter able to hold 0..n.
  function automatic int unsigned rc2_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rc2_phase_recover.sv
`timescale 1ns/1ps
module rc2_phase_recover
  import rc2_pkg::*;
#(
  parameter int unsigned ARM_EDGES = RC2_ARM_EDGES
) (
  input  logic clk_fast,
  input  logic rst,
  input  logic clk_slow,
  output logic slot_en
);
  localparam int unsigned CW = rc2_cnt_w(ARM_EDGES);

  logic          smp_fall;   // base clock seen half a fast period after each fast edge
  logic          smp_rise;   // same sample moved onto the rising fast edge
  logic [CW-1:0] seen;
  logic          armed;
  logic          phase_drop;

  // Falling-edge sampler: keeps the decision away from base-clock transitions.
  always_ff @(negedge clk_fast) begin
    if (rst) smp_fall <= 1'b0;
    else     smp_fall <= clk_slow;
  end

  assign armed      = (seen == CW'(ARM_EDGES));
  assign phase_drop = smp_rise & ~smp_fall;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      smp_rise <= 1'b0;
      seen     <= '0;
      slot_en  <= 1'b0;
    end else begin
      smp_rise <= smp_fall;
      if ((smp_fall != smp_rise) && !armed) seen <= seen + 1'b1;
      // A low sample following a high one means the base clock rises at this edge.
      slot_en  <= armed & phase_drop;
    end
  end
endmodule

// File: rtl/rc2_s2f_capture.sv
`timescale 1ns/1ps
module rc2_s2f_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_fast,
  input  logic          rst,
  input  logic          slot_en,
  input  logic [DW-1:0] s_in_data,
  input  logic          s_in_valid,
  output logic [DW-1:0] f_out_data,
  output logic          f_out_valid
);
  logic take;
  assign take = slot_en & s_in_valid;

  always_ff @(posedge clk_fast) begin
    if (rst) begin
      f_out_data  <= '0;
      f_out_valid <= 1'b0;
    end else begin
      f_out_valid <= take;
      if (take) f_out_data <= s_in_data;
    end
  end
endmodule

// File: rtl/rc2_f2s_hold.sv
`timescale 1ns/1ps
module rc2_f2s_hold #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_fast,
  input  logic          rst,
  input  logic          slot_en,
  input  logic [DW-1:0] f_in_data,
  input  logic          f_in_valid,
  output logic [DW-1:0] s_out_data,
  output logic          s_out_valid
);
  always_ff @(posedge clk_fast) begin
    if (rst) begin
      s_out_data  <= '0;
      s_out_valid <= 1'b0;
    end else if (slot_en) begin
      s_out_data  <= f_in_data;
      s_out_valid <= f_in_valid;
    end
  end
endmodule

// File: rtl/ratio2_xing.sv
`timescale 1ns/1ps
module ratio2_xing
  import rc2_pkg::*;
#(
  parameter int unsigned DW        = RC2_DW,
  parameter int unsigned ARM_EDGES = RC2_ARM_EDGES
) (
  input  logic          clk_fast,
  input  logic          rst,
  input  logic          clk_slow,
  input  logic [DW-1:0] s_in_data,
  input  logic          s_in_valid,
  output logic [DW-1:0] f_out_data,
  output logic          f_out_valid,
  input  logic [DW-1:0] f_in_data,
  input  logic          f_in_valid,
  output logic [DW-1:0] s_out_data,
  output logic          s_out_valid,
  output logic          slot_en
);
  rc2_phase_recover #(.ARM_EDGES(ARM_EDGES)) u_phase (
    .clk_fast (clk_fast),
    .rst      (rst),
    .clk_slow (clk_slow),
    .slot_en  (slot_en)
  );

  rc2_s2f_capture #(.DW(DW)) u_s2f (
    .clk_fast    (clk_fast),
    .rst         (rst),
    .slot_en     (slot_en),
    .s_in_data   (s_in_data),
    .s_in_valid  (s_in_valid),
    .f_out_data  (f_out_data),
    .f_out_valid (f_out_valid)
  );

  rc2_f2s_hold #(.DW(DW)) u_f2s (
    .clk_fast    (clk_fast),
    .rst         (rst),
    .slot_en     (slot_en),
    .f_in_data   (f_in_data),
    .f_in_valid  (f_in_valid),
    .s_out_data  (s_out_data),
    .s_out_valid (s_out_valid)
  );
endmodule

// File: rtl/rc2_checker.sv
`timescale 1ns/1ps
module rc2_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk_fast,
  input logic          rst,
  input logic          slot_en,
  input logic [DW-1:0] s_in_data,
  input logic          s_in_valid,
  input logic [DW-1:0] f_out_data,
  input logic          f_out_valid,
  input logic [DW-1:0] f_in_data,
  input logic          f_in_valid,
  input logic [DW-1:0] s_out_data,
  input logic          s_out_valid
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_fast) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: never two enable cycles back to back
  assert_en_alternate_R2: assert property (@(posedge clk_fast) disable iff (rst)
    slot_en |=> !slot_en);
  // R2: enable repeats every two fast cycles
  assert_en_period_R2: assert property (@(posedge clk_fast) disable iff (rst)
    slot_en |-> ##2 slot_en);
  // R3: quiet window after reset
  assert_arm_quiet_R3: assert property (@(posedge clk_fast) disable iff (rst)
    (since_rst < 2'd3) |-> !slot_en);
  // R4: a delivery pulse lasts one fast cycle
  assert_pulse_single_R4: assert property (@(posedge clk_fast) disable iff (rst)
    f_out_valid |=> !f_out_valid);
  // R4: a delivery pulse follows an enabled, valid base-rate word
  assert_pulse_source_R4: assert property (@(posedge clk_fast) disable iff (rst)
    f_out_valid |-> $past(slot_en && s_in_valid));
  // R5: delivered data only moves on an enabled, valid word
  assert_fdata_hold_R5: assert property (@(posedge clk_fast) disable iff (rst)
    !(slot_en && s_in_valid) |=> $stable(f_out_data));
  // R6 R7: held outputs change only at the edge closing an enable cycle
  assert_hold_stable_R6: assert property (@(posedge clk_fast) disable iff (rst)
    !slot_en |=> ($stable(s_out_data) && $stable(s_out_valid)));
  // R6: hold register loads what was offered
  assert_hold_load_R6: assert property (@(posedge clk_fast) disable iff (rst)
    slot_en |=> (s_out_data == $past(f_in_data) && s_out_valid == $past(f_in_valid)));
endmodule

bind ratio2_xing rc2_checker #(.DW(DW)) u_rc2_checker (
  .clk_fast    (clk_fast),
  .rst         (rst),
  .slot_en     (slot_en),
  .s_in_data   (s_in_data),
  .s_in_valid  (s_in_valid),
  .f_out_data  (f_out_data),
  .f_out_valid (f_out_valid),
  .f_in_data   (f_in_data),
  .f_in_valid  (f_in_valid),
  .s_out_data  (s_out_data),
  .s_out_valid (s_out_valid)
);

// File: tb/ratio2_xing_bench.sv
`timescale 1ns/1ps
module ratio2_xing_bench;
  localparam int DW = 16;
  localparam int RUN_CYCLES = 800;

  typedef struct {
    int          idx;
    logic        v;
    logic [15:0] d;
  } ent_t;

  logic          clk_fast = 1'b0;
  logic          clk_slow = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] s_in_data = '0;
  logic          s_in_valid = 1'b0;
  logic [DW-1:0] f_in_data = '0;
  logic          f_in_valid = 1'b0;
  logic [DW-1:0] f_out_data, s_out_data;
  logic          f_out_valid, s_out_valid, slot_en;

  int   checks = 0;
  int   errors = 0;
  int   q = 0;
  bit   run = 1'b0;
  bit   done = 1'b0;
  int   sent_valid = 0;
  int   got_valid = 0;
  ent_t sq[$];
  ent_t fq[$];
  real  skews[8] = '{0.5, 2.0, -2.0, 1.5, -1.5, 0.7, -1.0, -0.5};

  ratio2_xing #(.DW(DW)) u_ratio2_xing (
    .clk_fast    (clk_fast),
    .rst         (rst),
    .clk_slow    (clk_slow),
    .s_in_data   (s_in_data),
    .s_in_valid  (s_in_valid),
    .f_out_data  (f_out_data),
    .f_out_valid (f_out_valid),
    .f_in_data   (f_in_data),
    .f_in_valid  (f_in_valid),
    .s_out_data  (s_out_data),
    .s_out_valid (s_out_valid),
    .slot_en     (slot_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t q=%0d)", req, act, exp, $time, q);
    end
  endtask

  // 125 MHz fast clock
  always #4 clk_fast = ~clk_fast;
  initial forever begin
    @(posedge clk_fast);
    q++;
  end

  // Base clock: rises near even fast edges, falls near odd ones, each edge skewed (R8)
  initial begin
    int k;
    k = 0;
    forever begin
      int  nq;
      real sk;
      @(negedge clk_fast);
      nq = q + 1;
      sk = skews[k % 8];
      k++;
      #(4.0 + sk);
      clk_slow = ((nq % 2) == 0);
    end
  end

  // Base-rate producer: launches a word just after each rising edge
  initial begin
    int w;
    w = 0;
    forever begin
      @(posedge clk_slow);
      #0.3;
      if (run) begin
        ent_t e;
        w++;
        e.idx = q; e.v = ((w % 4) != 3); e.d = 16'h4000 + 16'(w);
        s_in_data = e.d; s_in_valid = e.v;
        if (e.v) sent_valid++;
        sq.push_back(e);
      end
    end
  end

  // Base-rate consumer: checks the held word on each rising edge (R6 R7)
  initial forever begin
    @(posedge clk_slow);
    if (run) begin
      int qn, target;
      qn = (q % 2 != 0) ? q + 1 : q;
      target = qn - 2;
      while (fq.size() > 0 && fq[0].idx < target) begin
        check(1'b0, "R6 lost hold word", 32'(fq[0].idx), 32'(target));
        void'(fq.pop_front());
      end
      if (fq.size() > 0 && fq[0].idx == target) begin
        ent_t e;
        e = fq.pop_front();
        check(s_out_valid == e.v, "R6 held valid", 32'(s_out_valid), 32'(e.v));
        check(s_out_data == e.d, "R6 R7 held data", 32'(s_out_data), 32'(e.d));
      end else begin
        check(s_out_valid == 1'b0, "R6 held valid idle", 32'(s_out_valid), 32'd0);
      end
    end
  end

  // Fast-side reference model, compared on every fast cycle
  initial begin
    logic [15:0] exp_fd;
    int          fw;
    int          wait_cnt;
    exp_fd = '0;
    fw = 0;
    repeat (6) @(posedge clk_fast);
    #1;
    // R1: reset state
    check(slot_en == 1'b0, "R1 slot_en", 32'(slot_en), 32'd0);
    check(f_out_valid == 1'b0, "R1 f_out_valid", 32'(f_out_valid), 32'd0);
    check(s_out_valid == 1'b0, "R1 s_out_valid", 32'(s_out_valid), 32'd0);
    check(f_out_data == '0, "R1 f_out_data", 32'(f_out_data), 32'd0);
    check(s_out_data == '0, "R1 s_out_data", 32'(s_out_data), 32'd0);
    rst = 1'b0;
    // R3: quiet for the first cycles after release
    @(posedge clk_fast); #1;
    check(slot_en == 1'b0, "R3 first cycle", 32'(slot_en), 32'd0);
    @(posedge clk_fast); #1;
    check(slot_en == 1'b0, "R3 second cycle", 32'(slot_en), 32'd0);
    wait_cnt = 0;
    while (!slot_en && wait_cnt < 10) begin
      @(posedge clk_fast); #1;
      wait_cnt++;
    end
    check(slot_en == 1'b1, "R3 enable starts", 32'(slot_en), 32'd1);
    check((q % 2) == 0, "R2 enable phase", 32'(q % 2), 32'd0);
    run = 1'b1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      if (c != 0) begin
        @(posedge clk_fast); #1;
      end
      // R2 R8: enable on even cycles only
      check(slot_en == ((q % 2) == 0), "R2 R8 slot_en", 32'(slot_en), 32'((q % 2) == 0));
      // R4 R5: delivery on odd cycles
      if ((q % 2) != 0 && sq.size() > 0) begin
        ent_t e;
        e = sq.pop_front();
        check(f_out_valid == e.v, e.v ? "R4 pulse" : "R5 no pulse", 32'(f_out_valid), 32'(e.v));
        if (e.v) exp_fd = e.d;
        if (f_out_valid) got_valid++;
      end else begin
        check(f_out_valid == 1'b0, "R4 off-phase pulse", 32'(f_out_valid), 32'd0);
      end
      check(f_out_data == exp_fd, "R4 R5 f_out_data", 32'(f_out_data), 32'(exp_fd));
      // Fast-side producer: real words in enable cycles, junk otherwise (R7)
      if (slot_en) begin
        ent_t e;
        fw++;
        e.idx = q; e.v = ((fw % 3) != 2); e.d = 16'h0100 + 16'(fw);
        f_in_data = e.d; f_in_valid = e.v;
        fq.push_back(e);
      end else begin
        f_in_data = 16'hDEAD; f_in_valid = 1'b1;
      end
    end
    run = 1'b0;
    // R4 R8: nothing lost or repeated across the whole skew sweep
    begin
      int pend;
      pend = 0;
      foreach (sq[i]) if (sq[i].v) pend++;
      check(got_valid + pend == sent_valid, "R4 R8 word count", 32'(got_valid + pend), 32'(sent_valid));
      check(sq.size() <= 1, "R4 backlog", 32'(sq.size()), 32'd1);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule